// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage of a pipelined processor. Each cycle it takes the fetch address and, in that same cycle and with no register on the path, answers two questions: is the instruction at this address a taken branch, and where does it go? Direction comes from a large, untagged table of two-bit saturating counters. Several branches can share one counter, and that sharing is accepted. The destination comes from a smaller, tagged target buffer.

The execute stage resolves every branch and jump and feeds the result back on an update port. The update port carries the instruction address, a flag that says it really was a control-transfer instruction, the actual direction and target, and the prediction that fetch made for it. From these the block trains its tables. One cycle later it also raises a mispredict flag and presents the correct address to restart from, so that the flush logic can repair the pipeline.

After reset the block walks the whole counter table once, one entry per cycle, and sets every counter to weakly not-taken. Updates that arrive during this walk are not stored.

Top module: `brp_top`

## Requirements
- R1: A synchronous reset clears the mispredict flag and the redirect address. Over the next 2^DIR_IDX_W cycles every counter is set to 01 and the target buffer is emptied. Until a taken branch is trained, every fetch address predicts not-taken.
- R2: A counter steps up on each taken update and stays at 11 once it reaches 11. A branch trained to 11 and then resolved not-taken once still predicts taken.
- R3: A counter steps down on each not-taken update and stays at 00 once it reaches 00. A counter driven to 00 and then resolved taken once still predicts not-taken.
- R4: pred_taken is 1 only when the target buffer hits and the counter is 10 or 11. pred_target is then the stored target; otherwise it is fetch_pc+4. Both are combinational in fetch_pc.
- R5: The counter index is PC bits [DIR_IDX_W+1:2] and carries no tag. Two branches with equal index bits share one counter.
- R6: The target buffer is indexed by PC bits [BTB_IDX_W+1:2] and tagged with bits [XLEN-1:BTB_IDX_W+2]. An entry is written (valid, tag, target) only by a taken update, and a not-taken update leaves the stored target unchanged. A tag mismatch predicts not-taken.
- R7: An update with upd_valid low changes no table and gives mispredict low in the next cycle.
- R8: One cycle after a valid update whose direction differs from upd_pred_taken, mispredict is 1. redirect_pc is then upd_target if the branch was taken, or upd_pc+4 if it was not.
- R9: One cycle after a valid taken update that was predicted taken but with upd_pred_target different from upd_target, mispredict is 1 and redirect_pc is upd_target. With equal targets, mispredict is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | XLEN | Address being fetched |
| pred_taken | output | 1 | Predicted taken for fetch_pc |
| pred_target | output | XLEN | Predicted next address for fetch_pc |
| upd_valid | input | 1 | Resolved instruction is a branch or jump |
| upd_pc | input | XLEN | Address of the resolved instruction |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | XLEN | Actual target when taken |
| upd_pred_taken | input | 1 | Direction predicted in fetch for it |
| upd_pred_target | input | XLEN | Target predicted in fetch for it |
| mispredict | output | 1 | Registered: last update was mispredicted |
| redirect_pc | output | XLEN | Registered: correct restart address |

## Verification
The bench builds the block with DIR_IDX_W=4 and BTB_IDX_W=5, so the counter table has 16 entries and the target buffer has 32. At these sizes the initialisation walk finishes within a few cycles. Two addresses 64 bytes apart share a counter but occupy separate target entries, which lets the effect of counter aliasing show directly in the prediction. Two addresses 128 bytes apart share both a counter and a target slot but differ in tag, which exercises tag misses. Random traffic over a small pool of addresses then makes aliasing, saturation and target replacement occur often.

// File: rtl/brp_pkg.sv
package brp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/brp_dir_table.sv
module brp_dir_table
  import brp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic             busy
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  ctr_t             mem [DEPTH];
  logic [IDX_W-1:0] sweep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b1;
      sweep <= '0;
    end else if (busy) begin
      sweep <= sweep + 1'b1;
      if (sweep == LAST) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (busy)        mem[sweep]  <= CTR_WEAK_NT;
      else if (wr_req) mem[wr_idx] <= ctr_next(mem[wr_idx], wr_taken);
    end
  end

  assign rd_taken = mem[rd_idx][1];
endmodule

// File: rtl/brp_tgt_buf.sv
module brp_tgt_buf #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-3:0] rd_wa,
  output logic            rd_hit,
  output logic [XLEN-1:0] rd_tgt,
  input  logic            wr_en,
  input  logic [XLEN-3:0] wr_wa,
  input  logic [XLEN-1:0] wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = XLEN - 2 - IDX_W;

  logic [DEPTH-1:0] valid;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [XLEN-1:0]  tgt_mem [DEPTH];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_wa[IDX_W-1:0];
  assign rd_tag = rd_wa[XLEN-3:IDX_W];
  assign wr_idx = wr_wa[IDX_W-1:0];
  assign wr_tag = wr_wa[XLEN-3:IDX_W];

  always_ff @(posedge clk) begin
    if (rst)        valid         <= '0;
    else if (wr_en) valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rst) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign rd_hit = valid[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  assign rd_tgt = tgt_mem[rd_idx];
endmodule

// File: rtl/brp_resolve.sv
module brp_resolve #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_valid,
  input  logic [XLEN-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [XLEN-1:0] upd_target,
  input  logic            upd_pred_taken,
  input  logic [XLEN-1:0] upd_pred_target,
  output logic            mispredict,
  output logic [XLEN-1:0] redirect_pc
);
  logic dir_wrong, tgt_wrong;

  assign dir_wrong = upd_taken != upd_pred_taken;
  assign tgt_wrong = upd_taken && (upd_target != upd_pred_target);

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= upd_valid && (dir_wrong || tgt_wrong);
      redirect_pc <= upd_taken ? upd_target : upd_pc + XLEN'(4);
    end
  end
endmodule

// File: rtl/brp_top.sv
module brp_top #(
  parameter int XLEN      = 32,
  parameter int DIR_IDX_W = 12,
  parameter int BTB_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [XLEN-1:0] pred_target,
  input  logic            upd_valid,
  input  logic [XLEN-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [XLEN-1:0] upd_target,
  input  logic            upd_pred_taken,
  input  logic [XLEN-1:0] upd_pred_target,
  output logic            mispredict,
  output logic [XLEN-1:0] redirect_pc
);
  logic            dir_taken, dir_busy, btb_hit;
  logic [XLEN-1:0] btb_tgt;
  logic            train;

  assign train = upd_valid && !dir_busy;

  brp_dir_table #(.IDX_W(DIR_IDX_W)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (fetch_pc[DIR_IDX_W+1:2]),
    .rd_taken (dir_taken),
    .wr_req   (train),
    .wr_idx   (upd_pc[DIR_IDX_W+1:2]),
    .wr_taken (upd_taken),
    .busy     (dir_busy)
  );

  brp_tgt_buf #(.XLEN(XLEN), .IDX_W(BTB_IDX_W)) u_btb (
    .clk    (clk),
    .rst    (rst),
    .rd_wa  (fetch_pc[XLEN-1:2]),
    .rd_hit (btb_hit),
    .rd_tgt (btb_tgt),
    .wr_en  (train && upd_taken),
    .wr_wa  (upd_pc[XLEN-1:2]),
    .wr_tgt (upd_target)
  );

  brp_resolve #(.XLEN(XLEN)) u_res (
    .clk             (clk),
    .rst             (rst),
    .upd_valid       (upd_valid),
    .upd_pc          (upd_pc),
    .upd_taken       (upd_taken),
    .upd_target      (upd_target),
    .upd_pred_taken  (upd_pred_taken),
    .upd_pred_target (upd_pred_target),
    .mispredict      (mispredict),
    .redirect_pc     (redirect_pc)
  );

  assign pred_taken  = btb_hit && dir_taken;
  assign pred_target = pred_taken ? btb_tgt : fetch_pc + XLEN'(4);
endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] fetch_pc,
  input logic            pred_taken,
  input logic [XLEN-1:0] pred_target,
  input logic            upd_valid,
  input logic [XLEN-1:0] upd_pc,
  input logic            upd_taken,
  input logic [XLEN-1:0] upd_target,
  input logic            upd_pred_taken,
  input logic [XLEN-1:0] upd_pred_target,
  input logic            mispredict,
  input logic [XLEN-1:0] redirect_pc
);
  // R4: a not-taken prediction falls through to the next word
  p_fallthrough_r4: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> pred_target == fetch_pc + XLEN'(4));

  // R7: no valid update, no mispredict in the following cycle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !mispredict);

  // R8: a direction mismatch always flags a mispredict
  p_dir_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_taken != upd_pred_taken)) |=> mispredict);

  // R8: a not-taken resolution restarts at the next word
  p_nt_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken) |=> redirect_pc == $past(upd_pc) + XLEN'(4));

  // R8: a taken resolution restarts at the actual target
  p_tk_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken) |=> redirect_pc == $past(upd_target));

  // R9: right direction but wrong target still flags a mispredict
  p_tgt_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_pred_taken && (upd_target != upd_pred_target))
      |=> mispredict);
endmodule

bind brp_top brp_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_brp_top.sv
module sim_brp_top;
  localparam int XL = 32;
  localparam int DW = 4;
  localparam int BW = 5;
  localparam int SWEEP = 1 << DW;

  logic          clk = 1'b0;
  logic          rst;
  logic [XL-1:0] fetch_pc, upd_pc, upd_target, upd_pred_target;
  logic          upd_valid, upd_taken, upd_pred_taken;
  logic          pred_taken, mispredict;
  logic [XL-1:0] pred_target, redirect_pc;

  always #2 clk = ~clk;

  brp_top #(.XLEN(XL), .DIR_IDX_W(DW), .BTB_IDX_W(BW)) u0 (.*);

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;

  // behavioural reference state
  int          m_ctr [SWEEP];
  bit          m_v   [1 << BW];
  logic [31:0] m_tag [1 << BW];
  logic [31:0] m_tgt [1 << BW];
  bit          e_mis;
  logic [31:0] e_red;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_ptk(input logic [31:0] pc);
    int bi = int'((pc >> 2) % (1 << BW));
    int di = int'((pc >> 2) % SWEEP);
    return m_v[bi] && (m_tag[bi] == (pc >> (BW + 2))) && (m_ctr[di] >= 2);
  endfunction

  function automatic logic [31:0] m_ptgt(input logic [31:0] pc);
    int bi = int'((pc >> 2) % (1 << BW));
    return m_ptk(pc) ? m_tgt[bi] : pc + 32'd4;
  endfunction

  task automatic step(input logic [31:0] fpc, input bit uv, input logic [31:0] upc,
                      input bit utk, input logic [31:0] utgt,
                      input bit uptk, input logic [31:0] uptgt);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = utk;
    upd_target = utgt; upd_pred_taken = uptk; upd_pred_target = uptgt;
    #1;
    chk("R4 pred_taken", {31'd0, pred_taken}, {31'd0, m_ptk(fpc)});
    chk("R4 pred_target", pred_target, m_ptgt(fpc));
    @(posedge clk);
    if (edges >= SWEEP && uv) begin
      int di = int'((upc >> 2) % SWEEP);
      int bi = int'((upc >> 2) % (1 << BW));
      if (utk) m_ctr[di] = (m_ctr[di] == 3) ? 3 : m_ctr[di] + 1;
      else     m_ctr[di] = (m_ctr[di] == 0) ? 0 : m_ctr[di] - 1;
      if (utk) begin
        m_v[bi] = 1'b1; m_tag[bi] = upc >> (BW + 2); m_tgt[bi] = utgt;
      end
    end
    edges++;
    e_mis = uv && ((utk != uptk) || (utk && utgt != uptgt));
    e_red = utk ? utgt : upc + 32'd4;
    @(negedge clk);
    chk("R8 mispredict", {31'd0, mispredict}, {31'd0, e_mis});
    if (e_mis) chk("R8 redirect_pc", redirect_pc, e_red);
  endtask

  task automatic br(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    step(pc, 1'b1, pc, tk, tgt, m_ptk(pc), m_ptgt(pc));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  localparam logic [31:0] B = 32'h100, T = 32'h200, A = 32'h140, C = 32'h180, I = 32'h114;

  initial begin
    logic [31:0] pool [7];
    pool = '{32'h100, 32'h140, 32'h180, 32'h104, 32'h1c0, 32'h03c, 32'h800};
    rst = 1'b1; fetch_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
    upd_target = '0; upd_pred_taken = 1'b0; upd_pred_target = '0;
    foreach (m_ctr[k]) m_ctr[k] = 1;
    foreach (m_v[k]) m_v[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 mispredict after reset", {31'd0, mispredict}, 32'd0);
    chk("R1 redirect after reset", redirect_pc, 32'd0);
    for (int k = 0; k < SWEEP + 4; k++) step(B, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    chk("R1 initial not-taken", {31'd0, pred_taken}, 32'd0);
    chk("R1 initial target", pred_target, B + 32'd4);

    br(B, 1'b1, T);
    chk("R8 direction mispredict", {31'd0, mispredict}, 32'd1);
    chk("R8 taken redirect", redirect_pc, T);
    chk("R2 taken after one step", {31'd0, pred_taken}, 32'd1);
    chk("R6 target stored", pred_target, T);

    br(B, 1'b1, T); br(B, 1'b1, T); br(B, 1'b0, T);
    chk("R8 not-taken redirect", redirect_pc, B + 32'd4);
    chk("R2 saturate at 11", {31'd0, pred_taken}, 32'd1);

    br(B, 1'b0, T); br(B, 1'b0, T); br(B, 1'b0, T); br(B, 1'b1, T);
    chk("R3 saturate at 00", {31'd0, pred_taken}, 32'd0);

    br(A, 1'b1, 32'h300); br(A, 1'b1, 32'h300);
    step(B, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    chk("R5 aliased counter", {31'd0, pred_taken}, 32'd1);
    chk("R5 aliased target", pred_target, T);

    step(C, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    chk("R6 tag miss", {31'd0, pred_taken}, 32'd0);
    chk("R6 tag miss target", pred_target, C + 32'd4);

    for (int k = 0; k < 3; k++) step(B, 1'b0, B, 1'b0, T, 1'b1, T);
    chk("R7 invalid update ignored", {31'd0, pred_taken}, 32'd1);
    chk("R7 no mispredict", {31'd0, mispredict}, 32'd0);

    step(B, 1'b1, B, 1'b1, 32'h250, 1'b1, T);
    chk("R9 target mispredict", {31'd0, mispredict}, 32'd1);
    chk("R9 redirect", redirect_pc, 32'h250);
    chk("R6 target replaced", pred_target, 32'h250);
    step(B, 1'b1, B, 1'b1, 32'h250, 1'b1, 32'h250);
    chk("R9 matching target", {31'd0, mispredict}, 32'd0);

    br(I, 1'b1, 32'h400); br(I, 1'b1, 32'h400);
    step(I, 1'b1, I, 1'b0, 32'h500, 1'b1, 32'h400);
    chk("R6 not-taken keeps target", pred_target, 32'h400);

    for (int k = 0; k < 600; k++) begin
      logic [31:0] fp = pool[$urandom_range(0, 6)];
      logic [31:0] up = pool[$urandom_range(0, 6)];
      logic [31:0] tg = 32'h1000 + 32'h10 * $urandom_range(0, 3);
      bit tk = 1'($urandom_range(0, 1));
      bit uv = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 1) == 0)
        step(fp, uv, up, tk, tg, m_ptk(up), m_ptgt(up));
      else
        step(fp, uv, up, tk, tg, 1'($urandom_range(0, 1)),
             32'h1000 + 32'h10 * $urandom_range(0, 3));
    end

    summary();
    $finish;
  end
endmodule